// File: doc/BRIEF.md
# Virtualization Control-Field Access Unit

This block holds a small set of virtual-machine control fields in registers. A requester reaches a field by issuing a single-cycle request. The request carries a 32-bit field encoding, a write flag, 64-bit write data and a flag that says whether the requester runs in 64-bit mode. Each catalogued field belongs to one of two classes. A natural-width field is as wide as the requester's mode. A fixed 64-bit field is always 64 bits wide in storage. Outside 64-bit mode it is reached 32 bits at a time, and a companion encoding one above its base reaches only its upper half.

The catalogue is a parameter. It is a packed list of base encodings and one class bit per field, so an integration can set its own field set without changing the logic. Every request gets a response in the next cycle: a done pulse, the read data, and an error flag when the encoding matches no catalogued field.

A two-state response machine sequences the unit. ST_IDLE means no response is due. ST_RESP means a response is being presented. The transition ACCEPT (ST_IDLE to ST_RESP) and the transition CHAIN (ST_RESP to ST_RESP) are both taken when a request is valid. The transition QUIET (ST_RESP to ST_IDLE) is taken when no request is valid. ST_IDLE also holds itself when no request is valid.

Top module: `vcf_access_unit`

## Requirements
- R1: `resp_done` is high in the cycle after each cycle in which `req_valid` is high, and low in the cycle after each cycle in which it is low.
- R2: A natural-width field accessed in 64-bit mode (`req_mode64`=1) writes all 64 bits, and a read returns all 64 bits.
- R3: A natural-width field accessed outside 64-bit mode stores the low 32 bits of the write data with bits 63:32 cleared. A read returns bits 31:0 zero-extended to 64 bits.
- R4: A fixed 64-bit field accessed at its base encoding in 64-bit mode writes and reads all 64 bits.
- R5: A fixed 64-bit field read at its base encoding outside 64-bit mode returns bits 31:0 of the field, with bits 63:32 of `resp_rdata` zero.
- R6: A write to a fixed 64-bit field at its base encoding outside 64-bit mode stores the low 32 bits of the write data and clears bits 63:32.
- R7: A read at base+1 of a fixed 64-bit field, in either mode, returns the field's bits 63:32 on `resp_rdata[31:0]`, with `resp_rdata[63:32]` zero.
- R8: A write at base+1 of a fixed 64-bit field, in either mode, loads `req_wdata[31:0]` into the field's bits 63:32 and keeps bits 31:0 unchanged.
- R9: The default catalogue has fixed 64-bit fields at 0x2004 and 0x2006 and natural-width fields at 0x681E and 0x6C00. Any other encoding, including 0x681F and 0x6C01, raises `resp_err` together with `resp_done` for one cycle. In that cycle `resp_rdata` is zero, and no field changes.
- R10: After reset all fields read as zero, and `resp_done` and `resp_err` are low.
- R11: The response to a valid write has `resp_rdata` zero and `resp_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_enc | input | 32 | Field encoding |
| req_mode64 | input | 1 | Requester runs in 64-bit mode |
| req_wdata | input | 64 | Write data |
| resp_rdata | output | 64 | Read data, zero for writes and errors |
| resp_done | output | 1 | Response present |
| resp_err | output | 1 | Encoding not in catalogue |

## Verification
All responses are registered. The done flag, the error flag and the read data are due exactly one clock edge after the request is presented. The bench drives each request on a falling edge and samples the outputs 1 ns after the next rising edge. A write becomes visible to a read issued in the following cycle. The bench therefore updates its model only after checking the write response, and back-to-back requests check both ordering and the CHAIN transition. Idle cycles are sampled in the same way to confirm that done falls.

// File: rtl/vcf_pkg.sv
package vcf_pkg;
    localparam int ENC_W  = 32;
    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_t;
endpackage

// File: rtl/vcf_decoder.sv
module vcf_decoder #(
    parameter int NUM_FIELDS = 4,
    parameter logic [NUM_FIELDS*32-1:0] FIELD_ENC = '0,
    parameter logic [NUM_FIELDS-1:0] FIELD_WIDE = '0,
    localparam int IDX_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      enc,
    output logic             hit,
    output logic             upper,
    output logic [IDX_W-1:0] idx
);
    logic [NUM_FIELDS-1:0] hit_base;
    logic [NUM_FIELDS-1:0] hit_high;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
        logic [31:0] base;
        assign base        = FIELD_ENC[g*32 +: 32];
        assign hit_base[g] = (enc == base);
        assign hit_high[g] = FIELD_WIDE[g] && (enc == base + 32'd1);
    end

    always_comb begin
        hit   = 1'b0;
        upper = 1'b0;
        idx   = '0;
        for (int i = NUM_FIELDS - 1; i >= 0; i--) begin
            if (hit_base[i] || hit_high[i]) begin
                hit   = 1'b1;
                upper = hit_high[i];
                idx   = IDX_W'(i);
            end
        end
    end

    // R9: a well-formed catalogue never matches two fields at once
    assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_base | hit_high));
endmodule

// File: rtl/vcf_store.sv
module vcf_store #(
    parameter int NUM_FIELDS = 4,
    localparam int IDX_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic             wr_upper,
    input  logic             wr_mode64,
    input  logic [63:0]      wdata,
    output logic [63:0]      rd_val
);
    logic [63:0] mem [NUM_FIELDS];
    logic [63:0] next_val;

    assign rd_val = mem[idx];

    always_comb begin
        if (wr_upper)
            next_val = {wdata[31:0], rd_val[31:0]};
        else if (wr_mode64)
            next_val = wdata;
        else
            next_val = {32'd0, wdata[31:0]};
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && (idx == IDX_W'(g)))
                mem[g] <= next_val;
        end
    end

    // R8: upper-half write keeps the low half
    assert_upper_keeps_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_upper |=> mem[$past(idx)][31:0] == $past(rd_val[31:0]));
    // R3 / R6: narrow base write clears the upper half
    assert_narrow_clears_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_upper && !wr_mode64 |=> mem[$past(idx)][63:32] == 32'd0);
endmodule

// File: rtl/vcf_resp_fsm.sv
module vcf_resp_fsm
    import vcf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_mode64,
    input  logic        hit,
    input  logic        upper,
    input  logic [63:0] rd_val,
    output logic [63:0] resp_rdata,
    output logic        resp_done,
    output logic        resp_err
);
    resp_state_t state, state_nx;
    logic [63:0] fmt;

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = req_valid ? ST_RESP : ST_IDLE;  // ACCEPT
            ST_RESP: state_nx = req_valid ? ST_RESP : ST_IDLE;  // CHAIN / QUIET
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        if (req_write || !hit) fmt = '0;
        else if (upper)        fmt = {32'd0, rd_val[63:32]};
        else if (req_mode64)   fmt = rd_val;
        else                   fmt = {32'd0, rd_val[31:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_rdata <= '0;
            resp_err   <= 1'b0;
        end else if (req_valid) begin
            resp_rdata <= fmt;
            resp_err   <= !hit;
        end else begin
            resp_rdata <= '0;
            resp_err   <= 1'b0;
        end
    end

    assign resp_done = (state == ST_RESP);

    assert_done_after_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_done);
    assert_no_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_done);
    assert_err_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !hit |=> resp_err && resp_rdata == 64'd0);
    assert_narrow_read_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && !req_mode64 |=> resp_rdata[63:32] == 32'd0);
endmodule

// File: rtl/vcf_access_unit.sv
module vcf_access_unit #(
    parameter int NUM_FIELDS = 4,
    parameter logic [NUM_FIELDS*32-1:0] FIELD_ENC =
        {32'h0000_6C00, 32'h0000_681E, 32'h0000_2006, 32'h0000_2004},
    parameter logic [NUM_FIELDS-1:0] FIELD_WIDE = 4'b0011
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_enc,
    input  logic        req_mode64,
    input  logic [63:0] req_wdata,
    output logic [63:0] resp_rdata,
    output logic        resp_done,
    output logic        resp_err
);
    localparam int IDX_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1;

    logic             hit, upper;
    logic [IDX_W-1:0] idx;
    logic [63:0]      rd_val;

    vcf_decoder #(.NUM_FIELDS(NUM_FIELDS), .FIELD_ENC(FIELD_ENC),
                  .FIELD_WIDE(FIELD_WIDE)) u_dec (
        .clk(clk), .rst_n(rst_n), .enc(req_enc),
        .hit(hit), .upper(upper), .idx(idx));

    vcf_store #(.NUM_FIELDS(NUM_FIELDS)) u_store (
        .clk(clk), .rst_n(rst_n), .idx(idx),
        .wr_en(req_valid && req_write && hit), .wr_upper(upper),
        .wr_mode64(req_mode64), .wdata(req_wdata), .rd_val(rd_val));

    vcf_resp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_mode64(req_mode64), .hit(hit), .upper(upper), .rd_val(rd_val),
        .resp_rdata(resp_rdata), .resp_done(resp_done), .resp_err(resp_err));

    // R11: write responses carry no data
    assert_write_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |=> resp_rdata == 64'd0);
endmodule

// File: tb/vcf_access_unit_bench.sv
`timescale 1ns/1ps
module vcf_access_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_mode64 = 1'b0;
    logic [31:0] req_enc = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] resp_rdata;
    logic        resp_done, resp_err;

    int n_tests = 0, n_fail = 0;
    logic [63:0] model [4];
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    vcf_access_unit u_vcf_access_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_enc(req_enc), .req_mode64(req_mode64), .req_wdata(req_wdata),
        .resp_rdata(resp_rdata), .resp_done(resp_done), .resp_err(resp_err));

    function automatic bit lookup(input logic [31:0] e, output int k, output bit up);
        logic [31:0] bases [4] = '{32'h2004, 32'h2006, 32'h681E, 32'h6C00};
        k = 0; up = 0;
        for (int i = 0; i < 4; i++) begin
            if (e == bases[i]) begin k = i; return 1; end
            if (i < 2 && e == bases[i] + 1) begin k = i; up = 1; return 1; end
        end
        return 0;
    endfunction

    function automatic logic [63:0] exp_read(input logic [63:0] v, input bit up, input bit m);
        if (up) return {32'd0, v[63:32]};
        if (m)  return v;
        return {32'd0, v[31:0]};
    endfunction

    function automatic logic [63:0] exp_write(input logic [63:0] v, input logic [63:0] d,
                                              input bit up, input bit m);
        if (up) return {d[31:0], v[31:0]};
        if (m)  return d;
        return {32'd0, d[31:0]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic req(input bit w, input logic [31:0] e, input bit m, input logic [63:0] d);
        int k; bit up; bit ok; string tag;
        logic [63:0] exp;
        ok = lookup(e, k, up);
        if (!ok)       tag = "R9";
        else if (w)    tag = "R11";
        else if (up)   tag = "R7";
        else if (k < 2) tag = m ? "R4" : "R5";
        else           tag = m ? "R2" : "R3";
        exp = (ok && !w) ? exp_read(model[k], up, m) : 64'd0;
        @(negedge clk);
        req_valid = 1; req_write = w; req_enc = e; req_mode64 = m; req_wdata = d;
        @(posedge clk); #1;
        chk("R1 done", {63'd0, resp_done}, 64'd1);
        chk({tag, " err"}, {63'd0, resp_err}, {63'd0, !ok});
        chk({tag, " rdata"}, resp_rdata, exp);
        if (ok && w) model[k] = exp_write(model[k], d, up, m);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 0;
        @(posedge clk); #1;
        chk("R1 idle done", {63'd0, resp_done}, 64'd0);
        chk("R9 idle err", {63'd0, resp_err}, 64'd0);
    endtask

    initial begin
        #100000;
        if (!done_flag) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] encs [10] = '{32'h2004, 32'h2005, 32'h2006, 32'h2007, 32'h681E,
                                   32'h681F, 32'h6C00, 32'h6C01, 32'h1234, 32'h2003};
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) model[i] = '0;
        #1;
        chk("R10 done at reset", {63'd0, resp_done}, 64'd0);
        chk("R10 err at reset", {63'd0, resp_err}, 64'd0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R10: all fields zero
        req(0, 32'h2004, 1, 0); req(0, 32'h2006, 1, 0);
        req(0, 32'h681E, 1, 0); req(0, 32'h6C00, 1, 0);
        idle();
        // R4 / R5 / R7 / R8
        req(1, 32'h2004, 1, 64'hA1B2C3D4_E5F60718);
        req(0, 32'h2004, 1, 0);
        req(0, 32'h2004, 0, 0);
        req(0, 32'h2005, 0, 0);
        req(0, 32'h2005, 1, 0);
        req(1, 32'h2005, 0, 64'hFFFF0000_11223344);   // R8
        req(0, 32'h2004, 1, 0);
        chk("R8 low kept", model[0], 64'h11223344_E5F60718);
        // R6
        req(1, 32'h2004, 0, 64'hDEADBEEF_CAFEF00D);
        req(0, 32'h2004, 1, 0);
        // R2 / R3
        req(1, 32'h681E, 1, 64'h01234567_89ABCDEF);
        req(0, 32'h681E, 1, 0);
        req(0, 32'h681E, 0, 0);
        req(1, 32'h681E, 0, 64'h77777777_55555555);
        req(0, 32'h681E, 1, 0);
        // R9: natural field has no upper alias, state unchanged
        req(1, 32'h681F, 1, 64'hFFFFFFFF_FFFFFFFF);
        req(1, 32'hFFFF_FFFF, 0, 64'h1);
        req(0, 32'h681E, 1, 0);
        req(0, 32'h6C01, 1, 0);
        idle();
        // random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 7) == 0) idle();
            else req(1'($urandom_range(0, 1)), encs[$urandom_range(0, 9)],
                     1'($urandom_range(0, 1)), {$urandom, $urandom});
        end
        idle();
        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule